// File: doc/BRIEF.md
# Legacy Interrupt Message Handshake Generator

This block sits between application logic that drives a level-sensitive legacy interrupt line and an upstream message transmitter. Each change of the line's level becomes one message request: a rising edge asks for an Assert_INTx message, and a falling edge asks for a Deassert_INTx message. Every request carries the 3-bit number of the function raising the interrupt.

The transmitter takes a request with a one-cycle ready strobe. Later it reports with a one-cycle done strobe that the message has gone out. The block then gives the application a one-cycle acknowledge. Only one message is ever in flight.

Edges that arrive while a message is in flight wait in a small counter of pending edges and are sent in order. The reported interrupt state therefore always returns to the live level, and every Assert keeps its matching Deassert. If the counter is full and another edge arrives, the newest queued edge and the new edge cancel each other as a pair. The message sequence stays alternating and paired.

Top module: `intx_msg_gen`

## Requirements
- R1: A rising edge of `irq_level_i` produces exactly one request with `msg_is_assert_o` = 1 (Assert). Once that message completes, the reported state is asserted.
- R2: A falling edge of `irq_level_i` produces exactly one request with `msg_is_assert_o` = 0 (Deassert).
- R3: `irq_ack_o` is high for exactly one cycle, in the cycle after the clock edge that samples `msg_done_i` high for an accepted message. It is low at all other times, including between accept and done.
- R4: `msg_func_o` holds the value of `func_id_i` sampled when the message was launched. It stays stable until the acknowledge, even if `func_id_i` changes.
- R5: At most one message is outstanding. `msg_req_o` stays high, with type and function stable, until the cycle in which `msg_ready_i` is sampled high, and it is low from the next cycle.
- R6: Edges that arrive while a message is in flight are sent afterwards, in arrival order and with alternating type. The reported state ends equal to the current level.
- R7: A pulse on `irq_level_i` that ends before its Assert is accepted still yields both an Assert and then a Deassert.
- R8: When PEND_DEPTH edges (default 4) are waiting and another edge arrives, the newest waiting edge is dropped together with the new one. No other edge is lost, and the types keep alternating.
- R9: After reset the reported state is deasserted, `msg_req_o` and `irq_ack_o` are low, and no request appears until the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level_i | input | 1 | Legacy interrupt level from the application |
| func_id_i | input | 3 | Function number N of the requesting function |
| msg_ready_i | input | 1 | Transmitter accepts the pending request (one cycle) |
| msg_done_i | input | 1 | Transmitter has sent the accepted message (one cycle) |
| msg_req_o | output | 1 | Message request, held until accepted |
| msg_is_assert_o | output | 1 | 1 = Assert_INTx, 0 = Deassert_INTx |
| msg_func_o | output | 3 | Function number carried by the message |
| irq_ack_o | output | 1 | One-cycle completion acknowledge to the application |

## Verification
The bench sends a one-cycle pulse on the level input. A design that only compares the level with the reported state would lose that pulse, or would leave an Assert without its Deassert. It also toggles the level and the function number while the transmitter stalls. A design that reads the function live, or that drops the follow-on edge, would send the wrong number or stop with the reported state differing from the level. A burst of six edges against a stalled transmitter fills the pending counter. A wrong overflow rule shows up as a broken alternation or as a wrong message count. Each message's acknowledge is checked for early firing before done and for length.

// File: rtl/intx_msg_pkg.sv
package intx_msg_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_WAIT = 2'd2,
    HS_ACK  = 2'd3
  } hs_state_e;

  // Next count of waiting edges. A launch removes one. A new edge adds one,
  // unless the counter is full; then the newest waiting edge and the new one
  // cancel as a pair, so the count drops by one and the parity is kept.
  function automatic int unsigned pend_next(input int unsigned cur,
                                            input logic        edge_seen,
                                            input logic        take,
                                            input int unsigned depth);
    int unsigned n;
    n = cur;
    if (take && n != 0) n = n - 1;
    if (edge_seen) begin
      if (n >= depth) n = n - 1;
      else            n = n + 1;
    end
    return n;
  endfunction

  // Kind of the next message follows from the state last reported.
  function automatic logic next_is_assert(input logic reported);
    return ~reported;
  endfunction

endpackage

// File: rtl/intx_edge_queue.sv
module intx_edge_queue #(
  parameter int PEND_DEPTH = 4,
  localparam int CNT_W = $clog2(PEND_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             take_i,
  output logic             pending_o,
  output logic             edge_o,
  output logic             level_q_o,
  output logic [CNT_W-1:0] count_o
);
  import intx_msg_pkg::*;

  logic             level_q;
  logic [CNT_W-1:0] count_q;
  logic             edge_w;

  assign edge_w = level_i ^ level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      count_q <= '0;
    end else begin
      level_q <= level_i;
      count_q <= CNT_W'(pend_next(int'(count_q), edge_w, take_i, PEND_DEPTH));
    end
  end

  assign pending_o = (count_q != '0);
  assign edge_o    = edge_w;
  assign level_q_o = level_q;
  assign count_o   = count_q;
endmodule

// File: rtl/intx_msg_fsm.sv
module intx_msg_fsm #(
  parameter int FUNC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic              ready_i,
  input  logic              done_i,
  output logic              req_o,
  output logic              is_assert_o,
  output logic [FUNC_W-1:0] func_o,
  output logic              ack_o,
  output logic              launch_o,
  output logic              accept_o,
  output logic              complete_o,
  output logic              waiting_o,
  output logic              reported_o
);
  import intx_msg_pkg::*;

  hs_state_e         state_q, state_d;
  logic [FUNC_W-1:0] func_q;
  logic              reported_q;
  logic              launch_w, accept_w, complete_w;

  assign launch_w   = (state_q == HS_IDLE) && pending_i;
  assign accept_w   = (state_q == HS_REQ)  && ready_i;
  assign complete_w = (state_q == HS_WAIT) && done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (launch_w)   state_d = HS_REQ;
      HS_REQ:  if (accept_w)   state_d = HS_WAIT;
      HS_WAIT: if (complete_w) state_d = HS_ACK;
      HS_ACK:                  state_d = HS_IDLE;
      default:                 state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= HS_IDLE;
      func_q     <= '0;
      reported_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch_w)   func_q     <= func_i;
      if (complete_w) reported_q <= ~reported_q;
    end
  end

  assign req_o       = (state_q == HS_REQ);
  assign ack_o       = (state_q == HS_ACK);
  assign waiting_o   = (state_q == HS_WAIT);
  assign is_assert_o = next_is_assert(reported_q);
  assign func_o      = func_q;
  assign launch_o    = launch_w;
  assign accept_o    = accept_w;
  assign complete_o  = complete_w;
  assign reported_o  = reported_q;
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen #(
  parameter int FUNC_W     = 3,
  parameter int PEND_DEPTH = 4,
  localparam int CNT_W = $clog2(PEND_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_level_i,
  input  logic [FUNC_W-1:0] func_id_i,
  input  logic              msg_ready_i,
  input  logic              msg_done_i,
  output logic              msg_req_o,
  output logic              msg_is_assert_o,
  output logic [FUNC_W-1:0] msg_func_o,
  output logic              irq_ack_o
);
  logic             pending_w, edge_w, level_q_w;
  logic [CNT_W-1:0] count_w;
  logic             launch_w, accept_w, complete_w, waiting_w, reported_w;

  intx_edge_queue #(.PEND_DEPTH(PEND_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (irq_level_i),
    .take_i    (launch_w),
    .pending_o (pending_w),
    .edge_o    (edge_w),
    .level_q_o (level_q_w),
    .count_o   (count_w)
  );

  intx_msg_fsm #(.FUNC_W(FUNC_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending_i   (pending_w),
    .func_i      (func_id_i),
    .ready_i     (msg_ready_i),
    .done_i      (msg_done_i),
    .req_o       (msg_req_o),
    .is_assert_o (msg_is_assert_o),
    .func_o      (msg_func_o),
    .ack_o       (irq_ack_o),
    .launch_o    (launch_w),
    .accept_o    (accept_w),
    .complete_o  (complete_w),
    .waiting_o   (waiting_w),
    .reported_o  (reported_w)
  );
endmodule

// File: rtl/intx_msg_chk.sv
module intx_msg_chk #(
  parameter int FUNC_W = 3,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_req_o,
  input logic              msg_ready_i,
  input logic              msg_is_assert_o,
  input logic [FUNC_W-1:0] msg_func_o,
  input logic              irq_ack_o,
  input logic              launch_w,
  input logic              complete_w,
  input logic              waiting_w,
  input logic              reported_w,
  input logic              level_q_w,
  input logic [CNT_W-1:0]  count_w
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req_o && !msg_ready_i) |=> (msg_req_o && $stable(msg_is_assert_o) && $stable(msg_func_o))); // R5
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req_o && msg_ready_i) |=> !msg_req_o); // R5
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    complete_w |=> (irq_ack_o && $past(waiting_w))); // R3
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |=> !irq_ack_o); // R3
  AST_FUNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_w && !launch_w) |-> $stable(msg_func_o)); // R4
  AST_REPORT_FOLLOWS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    complete_w |=> (reported_w == $past(msg_is_assert_o))); // R1
  AST_CONVERGED: assert property (@(posedge clk) disable iff (!rst_n)
    (count_w == '0 && !msg_req_o && !waiting_w && !irq_ack_o) |-> (reported_w == level_q_w)); // R6
endmodule

bind intx_msg_gen intx_msg_chk #(.FUNC_W(FUNC_W), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .msg_req_o       (msg_req_o),
  .msg_ready_i     (msg_ready_i),
  .msg_is_assert_o (msg_is_assert_o),
  .msg_func_o      (msg_func_o),
  .irq_ack_o       (irq_ack_o),
  .launch_w        (launch_w),
  .complete_w      (complete_w),
  .waiting_w       (waiting_w),
  .reported_w      (reported_w),
  .level_q_w       (level_q_w),
  .count_w         (count_w)
);

// File: tb/tb_intx_msg_gen.sv
`timescale 1ns/1ps
module tb_intx_msg_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_level_i = 1'b0;
  logic [2:0] func_id_i = 3'd0;
  logic       msg_ready_i = 1'b0;
  logic       msg_done_i = 1'b0;
  logic       msg_req_o, msg_is_assert_o, irq_ack_o;
  logic [2:0] msg_func_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intx_msg_gen dut (
    .clk(clk), .rst_n(rst_n), .irq_level_i(irq_level_i), .func_id_i(func_id_i),
    .msg_ready_i(msg_ready_i), .msg_done_i(msg_done_i), .msg_req_o(msg_req_o),
    .msg_is_assert_o(msg_is_assert_o), .msg_func_o(msg_func_o), .irq_ack_o(irq_ack_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Stand-in transmitter: wait for a request, stall, accept, then report done.
  task automatic serve(input logic exp_assert, input logic [2:0] exp_func,
                       input int stall, input string req);
    int t = 0;
    while (!msg_req_o && t < 100) begin @(negedge clk); t++; end
    check(msg_req_o === 1'b1, {req, " request present"}, int'(msg_req_o), 1);
    check(msg_is_assert_o === exp_assert, {req, " message type"}, int'(msg_is_assert_o), int'(exp_assert));
    check(msg_func_o === exp_func, {req, " R4 function number"}, int'(msg_func_o), int'(exp_func));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(msg_req_o === 1'b1 && msg_is_assert_o === exp_assert, "R5 request held while stalled",
            int'(msg_req_o), 1);
    end
    msg_ready_i = 1'b1;
    @(negedge clk);
    msg_ready_i = 1'b0;
    check(msg_req_o === 1'b0, "R5 request drops after accept", int'(msg_req_o), 0);
    @(negedge clk);
    check(irq_ack_o === 1'b0, "R3 no ack before done", int'(irq_ack_o), 0);
    check(msg_func_o === exp_func, "R4 function held until ack", int'(msg_func_o), int'(exp_func));
    msg_done_i = 1'b1;
    @(negedge clk);
    msg_done_i = 1'b0;
    check(irq_ack_o === 1'b1, "R3 ack after done", int'(irq_ack_o), 1);
    @(negedge clk);
    check(irq_ack_o === 1'b0, "R3 ack lasts one cycle", int'(irq_ack_o), 0);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_req_o !== 1'b0 || irq_ack_o !== 1'b0) seen = 1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(msg_req_o === 1'b0, "R9 no request after reset", int'(msg_req_o), 0);
    check(irq_ack_o === 1'b0, "R9 no ack after reset", int'(irq_ack_o), 0);
    expect_quiet(10, "R9 idle until first rising edge");
  endtask

  task automatic t_single_assert;
    func_id_i = 3'd5;
    irq_level_i = 1'b1;
    serve(1'b1, 3'd5, 2, "R1 rising edge");
    expect_quiet(8, "R1 exactly one assert");
  endtask

  task automatic t_single_deassert;
    func_id_i = 3'd2;
    irq_level_i = 1'b0;
    serve(1'b0, 3'd2, 0, "R2 falling edge");
    expect_quiet(8, "R2 exactly one deassert");
  endtask

  task automatic t_short_pulse;
    func_id_i = 3'd7;
    irq_level_i = 1'b1;
    @(negedge clk);
    irq_level_i = 1'b0;
    serve(1'b1, 3'd7, 1, "R7 pulse assert");
    serve(1'b0, 3'd7, 0, "R7 pulse deassert");
    expect_quiet(8, "R7 pair only");
  endtask

  task automatic t_toggle_in_flight;
    int t = 0;
    func_id_i = 3'd3;
    irq_level_i = 1'b1;
    while (!msg_req_o && t < 100) begin @(negedge clk); t++; end
    irq_level_i = 1'b0;
    func_id_i = 3'd6;
    serve(1'b1, 3'd3, 3, "R6 first in flight, R4 old function");
    serve(1'b0, 3'd6, 0, "R6 queued deassert");
    expect_quiet(8, "R6 converged");
  endtask

  task automatic t_overflow;
    int t = 0;
    func_id_i = 3'd1;
    irq_level_i = 1'b1;
    while (!msg_req_o && t < 100) begin @(negedge clk); t++; end
    func_id_i = 3'd4;
    for (int i = 0; i < 6; i++) begin
      irq_level_i = ~irq_level_i;
      @(negedge clk);
    end
    serve(1'b1, 3'd1, 1, "R8 in flight");
    serve(1'b0, 3'd4, 0, "R8 queued 1");
    serve(1'b1, 3'd4, 0, "R8 queued 2");
    serve(1'b0, 3'd4, 0, "R8 queued 3");
    serve(1'b1, 3'd4, 0, "R8 queued 4");
    expect_quiet(12, "R8 overflow pair dropped");
    irq_level_i = 1'b0;
    serve(1'b0, 3'd4, 0, "R2 final deassert");
    expect_quiet(8, "R6 settled");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_assert();
    t_single_deassert();
    t_short_pulse();
    t_toggle_in_flight();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule